// File: doc/BRIEF.md
# Heartbeat Watchdog Reset Supervisor

This block supervises a processor by watching a heartbeat pin. Once software enables it through an 8-bit configuration register, every rising or falling edge of the heartbeat restarts a timeout counter. If the counter runs out before the next edge, the block drives a fixed-length system reset pulse. The pulse appears on two complementary outputs. A manual reset pin starts the same pulse.

All durations are counted in ticks of a time-base strobe, `tick_i`, so the chip decides what real time one tick stands for. Two periods are available: a long one, which is the default, and a short one. After any reset pulse, the short mode waits one long period before it switches to the short period, and it switches only once a heartbeat edge has been seen. This gives a processor that is restarting time to recover.

A timeout clears the enable bit and the short-mode bit. While a pulse is active, the block takes no input: the heartbeat, the manual reset and configuration writes are all ignored.

The configuration write port uses a valid/ready handshake. `cfg_ready_o` is high whenever no reset pulse is active. A write transfers on a clock edge where `cfg_valid_i` and `cfg_ready_o` are both high. While ready is low, nothing transfers. The source may hold its word until ready returns, or it may withdraw the word, which then has no effect.

Top module: `wdog_supervisor`

## Requirements
- R1: After `rst_n` is released: `sys_rst_o` is 0, `sys_rst_no` is 1, `cfg_q_o` is 0x00, and `cfg_ready_o` is 1.
- R2: While configuration bit 7 (enable) is 0, no number of ticks produces a reset pulse.
- R3: With bit 7 = 1 and bit 4 (short select) = 0, a reset pulse starts on the LONG_TICKS-th tick after the counter last restarted, if no heartbeat edge arrives in between.
- R4: With bits 7 and 4 both 1, the first timeout after a reset is LONG_TICKS ticks. Once a heartbeat edge is seen, each later timeout is SHORT_TICKS ticks counted from the last edge.
- R5: A rising edge and a falling edge of `beat_i` each restart the timeout counter. `beat_i` passes through a two-flop synchronizer before edge detection.
- R6: A reset pulse lasts exactly PULSE_TICKS ticks. During the pulse, `sys_rst_o` is 1 and `sys_rst_no` is 0, and the two outputs are always complementary.
- R7: A timeout clears bits 7 and 4 of the configuration register. The other six bits keep their values.
- R8: A low level on `mr_n_i`, seen while no pulse is active, starts a PULSE_TICKS reset pulse. It leaves the configuration register unchanged.
- R9: While a pulse is active, `cfg_ready_o` is 0. Offered writes, heartbeat edges and the manual reset level have no effect.
- R10: An accepted configuration write restarts the timeout counter from zero.
- R11: When a reset pulse ends, the timeout counter starts from zero, and short mode again uses the long period first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one clock wide per tick |
| beat_i | input | 1 | Asynchronous heartbeat from the processor; either edge counts |
| mr_n_i | input | 1 | Asynchronous manual reset, active low |
| cfg_valid_i | input | 1 | Configuration write offered |
| cfg_ready_o | output | 1 | Configuration write can be accepted (no pulse active) |
| cfg_data_i | input | 8 | Configuration word; bit 7 = enable, bit 4 = short select |
| cfg_q_o | output | 8 | Readback of the configuration register |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The bench builds the block with LONG_TICKS = 6, SHORT_TICKS = 3 and PULSE_TICKS = 2. With periods this short, the bench can place a heartbeat edge at every tick position of the first long window in short mode, and it can count every timeout and pulse to the exact tick. It can also run full keep-alive sequences that alternate rising and falling edges. Manual reset, writes during a pulse and the long-first rule after a pulse each fit into a few dozen ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Width of a counter that holds 0 .. n-1, never below one bit.
  function automatic int cnt_width(input int n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  typedef struct packed {
    logic enable;
    logic short_sel;
  } wd_mode_t;

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/wdog_edge_det.sv
module wdog_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic mask_i,
  output logic edge_o
);

  logic prev_q;

  // The copy always follows the input, so edges during a mask are lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign edge_o = (lvl_i ^ prev_q) & ~mask_i;

endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int CFG_W     = 8,
  parameter int EN_BIT    = 7,
  parameter int SHORT_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             wr_valid_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             fire_i,
  output logic             wr_acc_o,
  output logic [CFG_W-1:0] cfg_o,
  output wdog_pkg::wd_mode_t mode_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] clr_mask;

  always_comb begin
    clr_mask            = '1;
    clr_mask[EN_BIT]    = 1'b0;
    clr_mask[SHORT_BIT] = 1'b0;
  end

  assign wr_acc_o = wr_valid_i & ~hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (fire_i)    cfg_q <= cfg_q & clr_mask;
    else if (wr_acc_o)  cfg_q <= wr_data_i;
  end

  assign cfg_o            = cfg_q;
  assign mode_o.enable    = cfg_q[EN_BIT];
  assign mode_o.short_sel = cfg_q[SHORT_BIT];

  AST_FIRE_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (!cfg_q[EN_BIT] && !cfg_q[SHORT_BIT])); // R7
  AST_FROZEN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int LONG_TICKS  = 16,
  parameter int SHORT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  wdog_pkg::wd_mode_t mode_i,
  input  logic beat_edge_i,
  input  logic restart_i,
  input  logic hold_i,
  output logic fire_o
);

  localparam int CW = wdog_pkg::cnt_width(LONG_TICKS);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic [CW-1:0] last;
  logic          clear;

  // Short period only after a heartbeat edge since the last reset.
  assign last  = (mode_i.short_sel && seen_q) ? LAST_SHORT : LAST_LONG;
  assign clear = restart_i | beat_edge_i | ~mode_i.enable;

  assign fire_o = mode_i.enable & ~hold_i & tick_i & ~restart_i &
                  ~beat_edge_i & (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (beat_edge_i) seen_q <= 1'b1;
      if (clear || fire_o) cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_edge_i && !hold_i) |=> (cnt_q == '0)); // R5
  AST_RESET_FORGETS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !seen_q); // R11
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !hold_i) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);

  localparam int PW = wdog_pkg::cnt_width(PULSE_TICKS);
  localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

  logic          active_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        pcnt_q   <= '0;
      end
    end else if (tick_i) begin
      if (pcnt_q == LAST) active_q <= 1'b0;
      else                pcnt_q   <= pcnt_q + 1'b1;
    end
  end

  assign active_o = active_q;

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && start_i) |=> active_q); // R8
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick_i) |=> active_q); // R6

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int LONG_TICKS  = 16,
  parameter int SHORT_TICKS = 2,
  parameter int PULSE_TICKS = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8,
  parameter int EN_BIT      = 7,
  parameter int SHORT_BIT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             beat_i,
  input  logic             mr_n_i,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic             sys_rst_o,
  output logic             sys_rst_no
);

  logic beat_s, mr_n_s, beat_edge, fire, wr_acc, in_rst;
  wdog_pkg::wd_mode_t mode;

  wdog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_beat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(beat_i), .q_o(beat_s));

  wdog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_mr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mr_n_i), .q_o(mr_n_s));

  wdog_edge_det i_beat_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(beat_s), .mask_i(in_rst), .edge_o(beat_edge));

  wdog_cfg_reg #(.CFG_W(CFG_W), .EN_BIT(EN_BIT), .SHORT_BIT(SHORT_BIT)) i_cfg (
    .clk(clk), .rst_n(rst_n), .hold_i(in_rst), .wr_valid_i(cfg_valid_i),
    .wr_data_i(cfg_data_i), .fire_i(fire), .wr_acc_o(wr_acc),
    .cfg_o(cfg_q_o), .mode_o(mode));

  wdog_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode),
    .beat_edge_i(beat_edge), .restart_i(wr_acc), .hold_i(in_rst), .fire_o(fire));

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(fire | ~mr_n_s),
    .active_o(in_rst));

  assign cfg_ready_o = ~in_rst;
  assign sys_rst_o   = in_rst;
  assign sys_rst_no  = ~in_rst;

  AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> sys_rst_o); // R3
  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q_o[EN_BIT] |-> !fire); // R2

endmodule

// File: tb/test_wdog_supervisor.sv
`timescale 1ns/1ps
module test_wdog_supervisor;

  localparam int LONG  = 6;
  localparam int SHORT = 3;
  localparam int PULSE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, beat = 1'b0, mr_n = 1'b1, cfg_valid = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic cfg_ready, rst_o, rst_no;
  logic [7:0] cfg_q;
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  wdog_supervisor #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .PULSE_TICKS(PULSE)) i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .beat_i(beat), .mr_n_i(mr_n),
    .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready), .cfg_data_i(cfg_data),
    .cfg_q_o(cfg_q), .sys_rst_o(rst_o), .sys_rst_no(rst_no));

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
    if (rst_no !== ~rst_o) check("R6 complement", int'(rst_no), int'(~rst_o));
  endtask

  task automatic toggle_beat();
    @(negedge clk) beat = ~beat;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk) begin cfg_valid = 1'b1; cfg_data = d; end
    @(negedge clk) cfg_valid = 1'b0;
  endtask

  // Ticks until sys_rst_o equals want; -1 if not within max.
  task automatic ticks_until(input logic want, input int max, output int n);
    n = 0;
    while (n < max && rst_o !== want) begin do_tick(); n++; end
    if (rst_o !== want) n = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 rst_o", int'(rst_o), 0);
    check("R1 rst_no", int'(rst_no), 1);
    check("R1 cfg_q", int'(cfg_q), 0);
    check("R1 ready", int'(cfg_ready), 1);

    // R2 disabled: no pulse whatever the tick count
    cfg_write(8'h10);
    ticks_until(1'b1, 3 * LONG, n);
    check("R2 disabled", n, -1);

    // R3 long timeout, bits 6..0 retained across fire (R7)
    for (int v = 0; v < 4; v++) begin
      cfg_write(8'h80 | 8'(v << 5) | 8'h03);
      ticks_until(1'b1, 4 * LONG, n);
      check("R3 long timeout", n, LONG);
      check("R7 bits cleared", int'(cfg_q), int'(8'(v << 5) | 8'h03));
      ticks_until(1'b0, 4 * PULSE, n);
      check("R6 pulse length", n, PULSE);
    end

    // R4 short mode without heartbeat: long first
    cfg_write(8'h90);
    ticks_until(1'b1, 4 * LONG, n);
    check("R4 first period long", n, LONG);
    check("R7 cleared", int'(cfg_q), 0);
    ticks_until(1'b0, 4 * PULSE, n);
    check("R11 pulse end", n, PULSE);

    // R4 sweep of heartbeat position within the first long window
    for (int k = 0; k < LONG; k++) begin
      cfg_write(8'h90 | 8'(k));
      for (int t = 0; t < k; t++) do_tick();
      check("R4 no early fire", int'(rst_o), 0);
      toggle_beat();
      ticks_until(1'b1, 4 * LONG, n);
      check("R4 short after beat", n, SHORT);
      check("R7 retain low bits", int'(cfg_q), k);
      ticks_until(1'b0, 4 * PULSE, n);
      check("R6 pulse length", n, PULSE);
    end

    // R5 rising and falling edges keep it alive
    cfg_write(8'h80);
    for (int e = 0; e < 4; e++) begin
      for (int t = 0; t < LONG - 1; t++) do_tick();
      toggle_beat();
      check("R5 kept alive", int'(rst_o), 0);
    end
    ticks_until(1'b1, 4 * LONG, n);
    check("R5 fire after last edge", n, LONG);
    ticks_until(1'b0, 4 * PULSE, n);

    // R10 rewrite restarts the counter
    cfg_write(8'h80);
    for (int t = 0; t < LONG - 2; t++) do_tick();
    cfg_write(8'h80);
    ticks_until(1'b1, 4 * LONG, n);
    check("R10 restart on write", n, LONG);
    ticks_until(1'b0, 4 * PULSE, n);

    // R8 manual reset; R9 inputs ignored; R11 long first afterwards
    cfg_write(8'h90);
    do_tick();
    toggle_beat();
    @(negedge clk) mr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 manual pulse", int'(rst_o), 1);
    check("R8 rst_no", int'(rst_no), 0);
    mr_n = 1'b1;
    check("R9 ready low", int'(cfg_ready), 0);
    cfg_write(8'h55);
    toggle_beat();
    toggle_beat();
    check("R9 write ignored", int'(cfg_q), 8'h90);
    ticks_until(1'b0, 4 * PULSE, n);
    check("R8 pulse length", n, PULSE);
    check("R8 cfg kept", int'(cfg_q), 8'h90);
    check("R9 ready back", int'(cfg_ready), 1);
    ticks_until(1'b1, 4 * LONG, n);
    check("R11 long first after reset", n, LONG);
    ticks_until(1'b0, 4 * PULSE, n);
    check("R6 final pulse", n, PULSE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule